// File: doc/BRIEF.md
# Ripple Bit-Slice Arithmetic Logic Unit

This block computes one of eight arithmetic or logic functions of two N-bit operands in a single combinational pass. The result is not chosen from whole-word results by a wide multiplexer. Each bit comes from a small one-bit slice instead. Every slice holds a full adder, a handful of gates and a local selector. One carry line runs from the lowest slice to the highest, and addition, subtraction and the signed comparison all use it.

For subtraction, one control line inverts the B bit going into every slice and seeds a carry of 1 into slice 0, so the chain computes A + ~B + 1. The signed less-than operation uses the same subtraction. It takes the sign of the difference, corrected by the overflow of that difference, and returns that bit as the least significant bit of the result. A status unit then derives the zero, negative, overflow and carry flags from the result and from the carries around the top slice. There is no clock and no state. Any change at the inputs settles at the outputs within the same cycle.

Top module: `alu_slice_core`

## Requirements
- R1: With op_sel 3'b000 the result is A OR B, with 3'b001 it is A AND B, and with 3'b110 it is A XOR B, bit by bit.
- R2: With op_sel 3'b100 the result is NOT(A AND B), and with 3'b101 it is NOT(A OR B), bit by bit.
- R3: With op_sel 3'b010 the result is (A + B) mod 2^N, and carry_out is bit N of the unsigned sum.
- R4: With op_sel 3'b011 the result is (A - B) mod 2^N, formed as A + ~B + 1. carry_out is the carry out of the top slice of that sum, which is 1 exactly when A >= B as unsigned values.
- R5: With op_sel 3'b111, result bit 0 is 1 exactly when A < B as two's-complement signed values, and this holds even when A - B overflows. All other result bits are 0.
- R6: zero is 1 exactly when every result bit is 0, for every operation.
- R7: negative always equals the most significant result bit.
- R8: For op_sel 3'b010, 3'b011 and 3'b111, overflow is the carry into the top slice XOR the carry out of it, which equals signed overflow of the sum or difference. For the five logic operations it is 0.
- R9: carry_out is 0 for the five logic operations and for 3'b111.
- R10: The block is purely combinational: all outputs reflect the current inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code (see R1 to R5) |
| result | output | WIDTH | Operation result |
| zero | output | 1 | All result bits are 0 |
| negative | output | 1 | Most significant result bit |
| overflow | output | 1 | Signed overflow of the arithmetic operations |
| carry_out | output | 1 | Carry out of the top slice for add and subtract |

## Verification
Every output is due zero cycles after its stimulus, because no register lies between the ports. The bench changes operands and the operation code just after a rising edge of its own clock. It samples result and flags at the following falling edge, half a period later, when the whole ripple chain has settled. Each operation code is exercised with random operands. Directed pairs cover the signed extremes, where add and subtract overflow and the less-than result would be wrong without the overflow correction.

// File: rtl/alu_slice_pkg.sv
// Shared types for the bit-slice ALU.
// Assumes: op codes are 3 bits, with values fixed by the requirements.
package alu_slice_pkg;

    // Operation codes presented on op_sel.
    typedef enum logic [2:0] {
        OP_OR   = 3'b000,
        OP_AND  = 3'b001,
        OP_ADD  = 3'b010,
        OP_SUB  = 3'b011,
        OP_NAND = 3'b100,
        OP_NOR  = 3'b101,
        OP_XOR  = 3'b110,
        OP_SLT  = 3'b111
    } alu_op_e;

    // Per-slice output selector choices.
    typedef enum logic [2:0] {
        PICK_OR   = 3'd0,
        PICK_AND  = 3'd1,
        PICK_SUM  = 3'd2,
        PICK_XOR  = 3'd3,
        PICK_LESS = 3'd4
    } pick_e;

    // Control bundle broadcast to all slices and to the flag unit.
    typedef struct packed {
        logic  b_invert;    // invert B into every slice
        logic  carry_seed;  // carry into slice 0
        pick_e pick;        // slice output selector
        logic  out_invert;  // invert the selected slice output
        logic  arith;       // overflow flag is meaningful
        logic  keep_carry;  // carry flag is meaningful
    } slice_ctl_t;

endpackage

// File: rtl/alu_op_decode.sv
// Operation decoder: turns the 3-bit op code into the slice controls.
// Assumes: all eight codes are defined, so there is no illegal code.
module alu_op_decode
    import alu_slice_pkg::*;
(
    input  logic [2:0] op_code,
    output slice_ctl_t ctl
);

    alu_op_e op;
    assign op = alu_op_e'(op_code);

    // Map each operation to a slice selector plus carry and invert controls.
    always_comb begin
        ctl = '{b_invert: 1'b0, carry_seed: 1'b0, pick: PICK_OR,
                out_invert: 1'b0, arith: 1'b0, keep_carry: 1'b0};
        case (op)
            OP_OR:   ctl.pick = PICK_OR;
            OP_AND:  ctl.pick = PICK_AND;
            OP_ADD: begin
                ctl.pick       = PICK_SUM;
                ctl.arith      = 1'b1;
                ctl.keep_carry = 1'b1;
            end
            OP_SUB: begin
                ctl.pick       = PICK_SUM;
                ctl.b_invert   = 1'b1;
                ctl.carry_seed = 1'b1;
                ctl.arith      = 1'b1;
                ctl.keep_carry = 1'b1;
            end
            OP_NAND: begin
                ctl.pick       = PICK_AND;
                ctl.out_invert = 1'b1;
            end
            OP_NOR: begin
                ctl.pick       = PICK_OR;
                ctl.out_invert = 1'b1;
            end
            OP_XOR:  ctl.pick = PICK_XOR;
            OP_SLT: begin
                ctl.pick       = PICK_LESS;
                ctl.b_invert   = 1'b1;
                ctl.carry_seed = 1'b1;
                ctl.arith      = 1'b1;
            end
            default: ctl.pick = PICK_OR;
        endcase
    end

endmodule

// File: rtl/alu_bit_slice.sv
// One-bit ALU slice: a full adder, bitwise gates and a local selector.
// Assumes: b_invert is only set for subtract-style operations, so the
// logic functions always see the true B bit.
module alu_bit_slice
    import alu_slice_pkg::*;
(
    input  logic  a_bit,
    input  logic  b_bit,
    input  logic  carry_in,
    input  logic  less_in,
    input  logic  b_invert,
    input  pick_e pick,
    input  logic  out_invert,
    output logic  res_bit,
    output logic  sum_bit,
    output logic  carry_out
);

    logic b_eff;
    logic picked;

    // Full adder on the possibly inverted B bit.
    always_comb begin
        b_eff     = b_bit ^ b_invert;
        sum_bit   = a_bit ^ b_eff ^ carry_in;
        carry_out = (a_bit & b_eff) | (carry_in & (a_bit ^ b_eff));
    end

    // Local selector followed by an optional output inversion.
    always_comb begin
        case (pick)
            PICK_OR:   picked = a_bit | b_eff;
            PICK_AND:  picked = a_bit & b_eff;
            PICK_SUM:  picked = sum_bit;
            PICK_XOR:  picked = a_bit ^ b_eff;
            PICK_LESS: picked = less_in;
            default:   picked = 1'b0;
        endcase
        res_bit = picked ^ out_invert;
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Status flag unit: zero, negative, overflow and carry from the result
// word and the carries around the top slice.
// Assumes: top_carry_in/out come from the most significant slice.
module alu_flag_unit #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] res_word,
    input  logic             top_carry_in,
    input  logic             top_carry_out,
    input  logic             arith,
    input  logic             keep_carry,
    output logic             zero,
    output logic             negative,
    output logic             overflow,
    output logic             carry_out
);

    localparam int MSB = WIDTH - 1;

    // Flag derivation, gated by operation class.
    always_comb begin
        zero      = ~|res_word;
        negative  = res_word[MSB];
        overflow  = arith & (top_carry_in ^ top_carry_out);
        carry_out = keep_carry & top_carry_out;
    end

endmodule

// File: rtl/alu_slice_core.sv
// Top of the bit-slice ALU: decoder, a generated ripple chain of slices,
// signed less-than correction and the flag unit.
// Assumes: WIDTH >= 2; purely combinational, no clock or reset.
module alu_slice_core
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             negative,
    output logic             overflow,
    output logic             carry_out
);

    localparam int MSB = WIDTH - 1;

    slice_ctl_t ctl;
    logic       top_ci;
    logic       top_co;
    logic       top_sum;
    logic       less_flag;

    alu_op_decode u_dec (
        .op_code (op_sel),
        .ctl     (ctl)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic ci;
        logic co;
        logic sum;
        logic less;

        if (i == 0) begin : g_first
            assign ci   = ctl.carry_seed;
            assign less = less_flag;
        end else begin : g_rest
            assign ci   = g_slice[i-1].co;
            assign less = 1'b0;
        end

        alu_bit_slice u_slice (
            .a_bit      (op_a[i]),
            .b_bit      (op_b[i]),
            .carry_in   (ci),
            .less_in    (less),
            .b_invert   (ctl.b_invert),
            .pick       (ctl.pick),
            .out_invert (ctl.out_invert),
            .res_bit    (result[i]),
            .sum_bit    (sum),
            .carry_out  (co)
        );
    end

    // Signed less-than: sign of A-B corrected by its overflow.
    always_comb begin
        top_ci    = g_slice[MSB].ci;
        top_co    = g_slice[MSB].co;
        top_sum   = g_slice[MSB].sum;
        less_flag = top_sum ^ (top_ci ^ top_co);
    end

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .res_word      (result),
        .top_carry_in  (top_ci),
        .top_carry_out (top_co),
        .arith         (ctl.arith),
        .keep_carry    (ctl.keep_carry),
        .zero          (zero),
        .negative      (negative),
        .overflow      (overflow),
        .carry_out     (carry_out)
    );

endmodule

// File: rtl/alu_slice_checker.sv
// Assertion checker for alu_slice_core, attached by bind.
// Assumes: combinational block, so immediate assertions on settled values.
module alu_slice_checker #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             negative,
    input logic             overflow,
    input logic             carry_out
);

    localparam int MSB = WIDTH - 1;

    logic logic_op;
    assign logic_op = (op_sel != 3'b010) && (op_sel != 3'b011) && (op_sel != 3'b111);

    // Relate flags and results to operands for the current op.
    always_comb begin
        a_r6_zero: assert (zero == (result == '0));
        a_r7_negative: assert (negative == result[MSB]);
        if (logic_op) begin
            a_r8_no_overflow: assert (!overflow);
        end
        if (logic_op || op_sel == 3'b111) begin
            a_r9_no_carry: assert (!carry_out);
        end
        if (op_sel == 3'b010) begin
            a_r3_add_sum: assert ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b}));
        end
        if (op_sel == 3'b011) begin
            a_r4_sub_diff: assert (result == op_a - op_b);
        end
        if (op_sel == 3'b111) begin
            a_r5_slt_value: assert (result == {{MSB{1'b0}}, ($signed(op_a) < $signed(op_b))});
        end
    end

endmodule

bind alu_slice_core alu_slice_checker #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .result    (result),
    .zero      (zero),
    .negative  (negative),
    .overflow  (overflow),
    .carry_out (carry_out)
);

// File: tb/tb_alu_slice_core.sv
// Self-checking bench for alu_slice_core: seeded random plus corner cases.
module tb_alu_slice_core;

    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic [2:0]   op_sel;
    logic [W-1:0] result;
    logic         zero, negative, overflow, carry_out;

    int  n_checks;
    int  n_errors;
    bit  finished;

    alu_slice_core #(.WIDTH(W)) dut (
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sel    (op_sel),
        .result    (result),
        .zero      (zero),
        .negative  (negative),
        .overflow  (overflow),
        .carry_out (carry_out)
    );

    // Free-running bench clock.
    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: result word from the requirements.
    function automatic logic [W-1:0] ref_result(input logic [2:0] op,
                                                input logic [W-1:0] a, input logic [W-1:0] b);
        case (op)
            3'b000:  return a | b;
            3'b001:  return a & b;
            3'b010:  return a + b;
            3'b011:  return a - b;
            3'b100:  return ~(a & b);
            3'b101:  return ~(a | b);
            3'b110:  return a ^ b;
            default: return {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
        endcase
    endfunction

    // Reference: signed overflow for arithmetic ops, 0 otherwise.
    function automatic logic ref_overflow(input logic [2:0] op,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] s;
        if (op == 3'b010) begin
            s = a + b;
            return (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
        end
        if (op == 3'b011 || op == 3'b111) begin
            s = a - b;
            return (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
        end
        return 1'b0;
    endfunction

    // Reference: carry flag for add and subtract, 0 otherwise.
    function automatic logic ref_carry(input logic [2:0] op,
                                       input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        if (op == 3'b010) begin
            s = {1'b0, a} + {1'b0, b};
            return s[W];
        end
        if (op == 3'b011) return a >= b;
        return 1'b0;
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'b000, 3'b001, 3'b110: return "R1";
            3'b100, 3'b101:         return "R2";
            3'b010:                 return "R3";
            3'b011:                 return "R4";
            default:                return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
                     tag, op_sel, op_a, op_b, act, exp);
        end
    endtask

    // Drive after a rising edge, sample at the falling edge (R10: zero latency).
    task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] er;
        @(posedge clk);
        op_sel = op;
        op_a   = a;
        op_b   = b;
        @(negedge clk);
        er = ref_result(op, a, b);
        check(op_tag(op), result, er);
        check("R6", W'(zero), W'(er == '0));
        check("R7", W'(negative), W'(er[W-1]));
        check("R8", W'(overflow), W'(ref_overflow(op, a, b)));
        check("R9", W'(carry_out), W'(ref_carry(op, a, b)));
    endtask

    localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAXN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ONES = '1;

    // Main stimulus sequence.
    initial begin
        int unused_seed;
        n_checks = 0;
        n_errors = 0;
        finished = 1'b0;
        rst_n    = 1'b0;
        op_sel   = 3'b000;
        op_a     = '0;
        op_b     = '0;
        unused_seed = $urandom(32'h1234_5678);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: OR of zeros gives zero result and zero flag set.
        @(negedge clk);
        check("R6", W'(zero), W'(1));
        check("R1", result, '0);

        // Directed corners for every op.
        for (int op = 0; op < 8; op++) begin
            apply(3'(op), MAXP, ONE);   // R3 max positive plus 1 overflows
            apply(3'(op), MAXN, ONE);   // R4/R5 most negative minus 1 overflows
            apply(3'(op), ONE, MAXN);   // R5 positive vs most negative
            apply(3'(op), MAXN, MAXP);
            apply(3'(op), ONES, ONES);
            apply(3'(op), '0, '0);
            apply(3'(op), ONES, ONE);   // R3 carry out with zero result
            apply(3'(op), MAXP, MAXP);  // R5 equal operands
        end

        // Seeded random vectors over all ops.
        for (int k = 0; k < 2000; k++) begin
            apply(3'($urandom_range(0, 7)), W'($urandom), W'($urandom));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule